// File: doc/BRIEF.md
# Walking Creature Behaviour Controller

This block is a Moore state machine that steers a single creature moving along a two-dimensional track. Each clock cycle it reads two side-contact sensors, a ground-present flag and a dig command. From these it decides whether the creature walks left, walks right, falls or digs. It remembers the walking direction while the creature falls or digs. It also counts how long each fall lasts, and a fall that is too long kills the creature when it lands.

Four status outputs report the activity, and at most one of them is high at a time. All four go low once the creature is dead, and they stay low until reset. The reset is asynchronous and active low. Assertion takes effect at once. Release is synchronised internally, so the machine reacts to inputs from the third rising edge after `rst_n` goes high.

Top module: `walker_fsm`

## Requirements
- R1: While `rst_n` is low the outputs are walk_left=1 and all others 0. After release the creature walks left until an input changes that.
- R2: A walking creature on ground that receives no dig command turns round. In the walk-left state `bump_left` turns it to walk right. In the walk-right state `bump_right` turns it to walk left. When both bumps arrive in the same cycle it also reverses.
- R3: A walking or digging creature that sees ground=0 at a clock edge enters a fall state and raises `falling`. When it sees ground=1 in a fall state, it walks on in the direction it had before the fall.
- R4: Bumps have no effect in the fall or dig states. A bump in the same cycle as the ground loss does not change the direction, and neither does a bump in the landing cycle.
- R5: A dig command is taken only by a walking creature on ground, and `digging` then rises. Digging goes on until ground=0. The creature then falls, and on landing it walks in its original direction.
- R6: A dig command given while ground=0, or while falling (including the landing cycle), is ignored.
- R7: For a walking creature, ground loss has priority over dig, and dig has priority over a turn.
- R8: A fall that lasted 20 cycles (`falling` high for 20 cycles) ends in walking. A fall of 21 or more cycles ends in the dead state, where all four outputs are 0 whatever the inputs, until reset.
- R9: A fall has no length limit and never ends in mid-air. `falling` stays high as long as ground=0, however long that is. A fall of hundreds of cycles still ends in death on landing, because the count does not wrap round.
- R10: The output vector {walk_left, walk_right, falling, digging} is exactly one-hot in every live state. It reads 1000 walking left, 0100 walking right, 0010 falling and 0001 digging.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| bump_left | input | 1 | Contact on the left side |
| bump_right | input | 1 | Contact on the right side |
| ground | input | 1 | 1 when the creature stands on ground |
| dig | input | 1 | Request to start digging |
| walk_left | output | 1 | Creature walks left |
| walk_right | output | 1 | Creature walks right |
| falling | output | 1 | Creature is falling |
| digging | output | 1 | Creature is digging |

## Verification
A wrong state register shows at the ports one cycle after the faulty edge, because the outputs decode the state directly. A lost direction memory stays hidden during a fall or dig. It only shows on the cycle after landing, as the wrong walk output. A wrong fall count gives no visible sign at all until landing. For that reason the tests probe falls of exactly 20 and 21 cycles and one very long fall, and each fall is checked on the cycle after ground returns.

// File: rtl/walker_pkg.sv
package walker_pkg;

  typedef enum logic [2:0] {
    ST_WALK_L = 3'd0,
    ST_WALK_R = 3'd1,
    ST_FALL_L = 3'd2,
    ST_FALL_R = 3'd3,
    ST_DIG_L  = 3'd4,
    ST_DIG_R  = 3'd5,
    ST_DEAD   = 3'd6
  } walker_state_e;

  typedef struct packed {
    logic walk_l;
    logic walk_r;
    logic fall;
    logic dig;
  } walker_out_t;

endpackage

// File: rtl/walker_rst_sync.sv
module walker_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/walker_fall_ctr.sv
module walker_fall_ctr #(
  parameter int FALL_LIMIT = 20,
  localparam int CNT_W = $clog2(FALL_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_fall,
  output logic long_fall
);

  localparam logic [CNT_W-1:0] LIM = CNT_W'(FALL_LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Count cycles already spent falling; hold at the limit.
  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (!in_fall) begin
      cnt_d = '0;
    end else if (cnt_q != LIM) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // In the current fall cycle the fall has lasted cnt_q + 1 cycles.
  assign long_fall = (cnt_q == LIM);

endmodule

// File: rtl/walker_next_state.sv
module walker_next_state
  import walker_pkg::*;
(
  input  walker_state_e state_q,
  input  logic          bump_left,
  input  logic          bump_right,
  input  logic          ground,
  input  logic          dig,
  input  logic          long_fall,
  output walker_state_e state_d
);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WALK_L: begin
        if (!ground)        state_d = ST_FALL_L;
        else if (dig)       state_d = ST_DIG_L;
        else if (bump_left) state_d = ST_WALK_R;
      end
      ST_WALK_R: begin
        if (!ground)         state_d = ST_FALL_R;
        else if (dig)        state_d = ST_DIG_R;
        else if (bump_right) state_d = ST_WALK_L;
      end
      ST_FALL_L: begin
        if (ground) state_d = long_fall ? ST_DEAD : ST_WALK_L;
      end
      ST_FALL_R: begin
        if (ground) state_d = long_fall ? ST_DEAD : ST_WALK_R;
      end
      ST_DIG_L: begin
        if (!ground) state_d = ST_FALL_L;
      end
      ST_DIG_R: begin
        if (!ground) state_d = ST_FALL_R;
      end
      ST_DEAD: state_d = ST_DEAD;
      default: state_d = ST_DEAD;
    endcase
  end

endmodule

// File: rtl/walker_fsm.sv
module walker_fsm
  import walker_pkg::*;
#(
  parameter int FALL_LIMIT = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bump_left,
  input  logic bump_right,
  input  logic ground,
  input  logic dig,
  output logic walk_left,
  output logic walk_right,
  output logic falling,
  output logic digging
);

  logic          rst_sync_n;
  walker_state_e state_q;
  walker_state_e state_d;
  logic          in_fall;
  logic          long_fall;
  walker_out_t   out_vec;

  walker_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign in_fall = (state_q == ST_FALL_L) || (state_q == ST_FALL_R);

  walker_fall_ctr #(.FALL_LIMIT(FALL_LIMIT)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_fall   (in_fall),
    .long_fall (long_fall)
  );

  walker_next_state u_ns (
    .state_q    (state_q),
    .bump_left  (bump_left),
    .bump_right (bump_right),
    .ground     (ground),
    .dig        (dig),
    .long_fall  (long_fall),
    .state_d    (state_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_WALK_L;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    out_vec = '0;
    unique case (state_q)
      ST_WALK_L:           out_vec.walk_l = 1'b1;
      ST_WALK_R:           out_vec.walk_r = 1'b1;
      ST_FALL_L, ST_FALL_R: out_vec.fall  = 1'b1;
      ST_DIG_L, ST_DIG_R:  out_vec.dig    = 1'b1;
      default:             out_vec        = '0;
    endcase
  end

  assign walk_left  = out_vec.walk_l;
  assign walk_right = out_vec.walk_r;
  assign falling    = out_vec.fall;
  assign digging    = out_vec.dig;

endmodule

// File: rtl/walker_fsm_chk.sv
module walker_fsm_chk (
  input logic clk,
  input logic rst_n,
  input logic rst_ok,
  input logic bump_left,
  input logic bump_right,
  input logic ground,
  input logic dig,
  input logic walk_left,
  input logic walk_right,
  input logic falling,
  input logic digging
);

  // R1: reset forces walking left
  a_r1_reset_walk_left: assert property (@(posedge clk)
    !rst_n |-> (walk_left && !walk_right && !falling && !digging));

  // R10: never more than one activity
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0({walk_left, walk_right, falling, digging}));

  // R3: losing ground while walking or digging starts a fall
  a_r3_fall_on_loss: assert property (@(posedge clk) disable iff (!rst_ok)
    (walk_left || walk_right || digging) && !ground |=> falling);

  // R9: no death while still in the air
  a_r9_no_midair_death: assert property (@(posedge clk) disable iff (!rst_ok)
    falling && !ground |=> falling);

  // R4: bumps do not interrupt digging on ground
  a_r4_dig_holds: assert property (@(posedge clk) disable iff (!rst_ok)
    digging && ground |=> digging);

  // R2: left bump while walking left turns right
  a_r2_turn_right: assert property (@(posedge clk) disable iff (!rst_ok)
    walk_left && ground && !dig && bump_left |=> walk_right);

  // R8: dead state is terminal
  a_r8_dead_sticky: assert property (@(posedge clk) disable iff (!rst_ok)
    !(walk_left || walk_right || falling || digging) |=>
      !(walk_left || walk_right || falling || digging));

endmodule

bind walker_fsm walker_fsm_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_ok     (rst_sync_n),
  .bump_left  (bump_left),
  .bump_right (bump_right),
  .ground     (ground),
  .dig        (dig),
  .walk_left  (walk_left),
  .walk_right (walk_right),
  .falling    (falling),
  .digging    (digging)
);

// File: tb/walker_fsm_tb_top.sv
`timescale 1ns/1ps
module walker_fsm_tb_top;

  logic clk;
  logic rst_n;
  logic bump_left, bump_right, ground, dig;
  logic walk_left, walk_right, falling, digging;

  int n_tests = 0;
  int n_fail  = 0;

  localparam logic [3:0] O_WL   = 4'b1000;
  localparam logic [3:0] O_WR   = 4'b0100;
  localparam logic [3:0] O_FALL = 4'b0010;
  localparam logic [3:0] O_DIG  = 4'b0001;
  localparam logic [3:0] O_DEAD = 4'b0000;

  walker_fsm dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bump_left  (bump_left),
    .bump_right (bump_right),
    .ground     (ground),
    .dig        (dig),
    .walk_left  (walk_left),
    .walk_right (walk_right),
    .falling    (falling),
    .digging    (digging)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {walk_left, walk_right, falling, digging};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive inputs at the falling edge, then sample 1 ns after the rising edge.
  task automatic step(input logic bl, input logic br, input logic g, input logic d);
    @(negedge clk);
    bump_left = bl; bump_right = br; ground = g; dig = d;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bump_left = 1'b0; bump_right = 1'b0; ground = 1'b1; dig = 1'b0;
    #1;
    check(O_WL, "R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(O_WL, "R1 after release");
  endtask

  task automatic t_turns();
    step(1, 0, 1, 0); check(O_WR, "R2 left bump turns right");
    step(0, 0, 1, 0); check(O_WR, "R10 walking right vector");
    step(0, 1, 1, 0); check(O_WL, "R2 right bump turns left");
    step(1, 1, 1, 0); check(O_WR, "R2 both bumps reverse from left");
    step(1, 1, 1, 0); check(O_WL, "R2 both bumps reverse from right");
  endtask

  task automatic t_fall_bumps();
    step(1, 0, 0, 0); check(O_FALL, "R4 bump with ground loss falls");
    step(1, 1, 0, 0); check(O_FALL, "R4 bumps while falling");
    step(1, 0, 1, 0); check(O_WL, "R3 R4 lands walking left despite bump");
    step(1, 0, 1, 0); check(O_WR, "R2 turn after landing");
    step(0, 0, 0, 0); check(O_FALL, "R3 fall from walking right");
    step(0, 1, 1, 0); check(O_WR, "R3 lands walking right");
  endtask

  task automatic t_dig();
    step(0, 0, 1, 1); check(O_DIG, "R5 dig accepted from walking right");
    step(0, 1, 1, 0); check(O_DIG, "R4 bump while digging");
    step(1, 1, 1, 1); check(O_DIG, "R5 digging continues");
    step(0, 0, 0, 0); check(O_FALL, "R5 dig through to fall");
    step(0, 0, 1, 0); check(O_WR, "R5 keeps direction after dig");
  endtask

  task automatic t_dig_ignored();
    step(0, 0, 0, 1); check(O_FALL, "R6 dig without ground ignored");
    step(0, 0, 0, 1); check(O_FALL, "R6 dig while falling ignored");
    step(0, 0, 1, 1); check(O_WR, "R6 dig on landing cycle ignored");
  endtask

  task automatic t_priority();
    step(0, 1, 0, 1); check(O_FALL, "R7 ground loss beats dig and turn");
    step(0, 0, 1, 0); check(O_WR, "R7 landed walking right");
    step(0, 1, 1, 1); check(O_DIG, "R7 dig beats turn");
    step(0, 0, 0, 0); check(O_FALL, "R7 leave dig");
    step(0, 0, 1, 0); check(O_WR, "R7 direction kept");
  endtask

  task automatic fall_for(input int n, input logic [3:0] exp_land, input string tag);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 0, 0);
      if (i == 0 || i == n - 1) check(O_FALL, tag);
    end
    step(0, 0, 1, 0); check(exp_land, tag);
  endtask

  task automatic t_fall_limits();
    fall_for(20, O_WR, "R8 twenty cycle fall survives");
    fall_for(21, O_DEAD, "R8 twenty-one cycle fall kills");
    step(1, 0, 1, 1); check(O_DEAD, "R8 dead ignores inputs");
    step(0, 0, 0, 0); check(O_DEAD, "R8 dead ignores ground loss");
    do_reset();
  endtask

  task automatic t_long_fall();
    int bad;
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      step(0, 0, 0, 0);
      if ({walk_left, walk_right, falling, digging} !== O_FALL) bad++;
    end
    n_tests++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL R9: %0d of 300 cycles not falling, expected 0", bad);
    end
    step(0, 0, 1, 0); check(O_DEAD, "R9 long fall dies on landing");
    do_reset();
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bump_left = 1'b0; bump_right = 1'b0; ground = 1'b1; dig = 1'b0;
    do_reset();
    t_turns();
    t_fall_bumps();
    t_dig();
    t_dig_ignored();
    t_priority();
    t_fall_limits();
    t_long_fall();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule